// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory access from a group of 32 lanes and reduces it to the fewest aligned bus transactions that cover it. Each lane gives a byte address for one 4-byte word and an active flag. A granularity select picks 128-byte lines or 32-byte segments as the transaction unit. The block sends one transaction for each distinct aligned block that the active lanes touch. Each transaction carries the block base address and a mask of the lanes it serves.

The block accepts a request, stores the lane addresses and then produces one transaction per cycle over a valid/ready output. In each cycle it picks the lowest-numbered active lane that has not been served yet. It clears that lane's low address bits to get the block base. In the same cycle it marks every unserved lane whose base is the same. After the last transaction is accepted, a one-cycle done pulse gives the transaction count and the number of bytes that cross the bus.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0. A reset that arrives while a request is being processed drops that request.
- R2: With req_seg = 0 (line mode), txn_base is the lane address with bits [6:0] cleared. Exactly one transaction is issued for each distinct 128-byte line that the active lanes touch, whatever the order of the lanes.
- R3: With req_seg = 1 (segment mode), txn_base is the lane address with bits [4:0] cleared. Exactly one transaction is issued for each distinct 32-byte segment that the active lanes touch.
- R4: Bit i of txn_mask stands for lane i, where lane i's address is req_addr[32*i+31:32*i]. Transactions come out in the order of their lowest-numbered unserved active lane, and every active lane appears in exactly one transaction.
- R5: Inactive lanes add no address and no mask bit. A request with no active lanes produces no transaction. Its done pulse comes in the cycle after acceptance, with a count of 0 and 0 bytes.
- R6: While txn_valid is 1 and txn_ready is 0, txn_valid stays 1 and txn_base and txn_mask do not change.
- R7: req_ready is 1 only when the block is idle. It is 0 from the cycle after a request with active lanes is accepted until the done pulse. txn_valid and req_ready are never 1 together.
- R8: done is 1 for one cycle, in the cycle after the handshake of the last transaction. done_count is the number of transactions. done_bytes is done_count times 128 in line mode and times 32 in segment mode.
- R9: While txn_ready stays 1, one transaction is handed off per cycle. For a request that needs N transactions, done is seen N+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and takes the request |
| req_seg | input | 1 | Granularity: 0 = 128-byte line, 1 = 32-byte segment |
| req_active | input | 32 | Lane active flags, bit i = lane i |
| req_addr | input | 1024 | Packed lane byte addresses, lane i at [32*i+31:32*i] |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | 32 | Aligned block base address |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when the request is finished |
| done_count | output | 6 | Transactions issued for the request |
| done_bytes | output | 13 | Bytes moved for the request |

## Verification
The bench covers these corner cases, and for each one says how a faulty design would show up:
- **Reversed lane order.** A design that assumes addresses rise with lane number would split one line into several transactions.
- **Start offset of 4 bytes versus 32 bytes.** This separates the five-segment case from the four-segment case. A wrong mask width makes the count or the bases come out wrong.
- **All lanes reading the same word.** A design that does not merge equal addresses would send 32 transactions instead of one.
- **Active lanes next to inactive lanes that point at unrelated lines.** This catches a design that lets inactive addresses produce transactions or mask bits.
- **Held-back ready.** A design that moves its output during a stall, or drops a served lane, fails the stability check.
- **Cycle count to done.** This exposes a design that adds dead cycles between transactions.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic {
        GRAN_LINE = 1'b0,
        GRAN_SEG  = 1'b1
    } gran_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;

    localparam int unsigned DEF_LINE_LOG2 = 7;
    localparam int unsigned DEF_SEG_LOG2  = 5;

    // Mask that keeps the block-base bits for the selected granularity
    function automatic logic [63:0] block_mask(gran_e g, int unsigned line_log2,
                                               int unsigned seg_log2);
        return {64{1'b1}} << ((g == GRAN_SEG) ? seg_log2 : line_log2);
    endfunction

endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign found = |pend;
endmodule

// File: rtl/coal_matcher.sv
module coal_matcher
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = DEF_LINE_LOG2,
    parameter int SEG_LOG2  = DEF_SEG_LOG2,
    localparam int IDX_W    = $clog2(LANES)
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addr,
    input  logic [LANES-1:0]             pend,
    input  logic [IDX_W-1:0]             lead,
    input  gran_e                        gran,
    output logic [ADDR_W-1:0]            base,
    output logic [LANES-1:0]             match
);
    logic [ADDR_W-1:0] keep;

    assign keep = ADDR_W'(block_mask(gran, LINE_LOG2, SEG_LOG2));
    assign base = addr[lead] & keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign match[g] = pend[g] && ((addr[g] & keep) == base);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = DEF_LINE_LOG2,
    parameter int SEG_LOG2  = DEF_SEG_LOG2,
    localparam int IDX_W    = $clog2(LANES),
    localparam int CNT_W    = $clog2(LANES + 1),
    localparam int BYTES_W  = CNT_W + LINE_LOG2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_seg,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        done_count,
    output logic [BYTES_W-1:0]      done_bytes
);
    state_e                        state;
    gran_e                         gran_q;
    logic [LANES-1:0][ADDR_W-1:0]  addr_q;
    logic [LANES-1:0]              pend_q;
    logic [CNT_W-1:0]              cnt_q;

    logic                          found;
    logic [IDX_W-1:0]              lead;
    logic [LANES-1:0]              match;
    logic [ADDR_W-1:0]             base;
    logic [LANES-1:0]              pend_left;
    logic [CNT_W-1:0]              cnt_next;
    logic [BYTES_W-1:0]            bytes_next;

    coal_leader #(.LANES(LANES)) u_leader (
        .pend  (pend_q),
        .found (found),
        .idx   (lead)
    );

    coal_matcher #(
        .LANES(LANES), .ADDR_W(ADDR_W),
        .LINE_LOG2(LINE_LOG2), .SEG_LOG2(SEG_LOG2)
    ) u_match (
        .addr  (addr_q),
        .pend  (pend_q),
        .lead  (lead),
        .gran  (gran_q),
        .base  (base),
        .match (match)
    );

    assign req_ready  = (state == ST_IDLE);
    assign txn_valid  = (state == ST_BUSY) && found;
    assign txn_base   = base;
    assign txn_mask   = match;
    assign pend_left  = pend_q & ~match;
    assign cnt_next   = cnt_q + 1'b1;
    assign bytes_next = (gran_q == GRAN_SEG) ? (BYTES_W'(cnt_next) << SEG_LOG2)
                                             : (BYTES_W'(cnt_next) << LINE_LOG2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            gran_q     <= GRAN_LINE;
            addr_q     <= '0;
            pend_q     <= '0;
            cnt_q      <= '0;
            done       <= 1'b0;
            done_count <= '0;
            done_bytes <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        gran_q <= gran_e'(req_seg);
                        pend_q <= req_active;
                        cnt_q  <= '0;
                        if (req_active == '0) begin
                            done       <= 1'b1;
                            done_count <= '0;
                            done_bytes <= '0;
                        end else begin
                            state <= ST_BUSY;
                        end
                    end
                end
                ST_BUSY: begin
                    if (txn_valid && txn_ready) begin
                        pend_q <= pend_left;
                        cnt_q  <= cnt_next;
                        if (pend_left == '0) begin
                            state      <= ST_IDLE;
                            done       <= 1'b1;
                            done_count <= cnt_next;
                            done_bytes <= bytes_next;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int LINE_LOG2 = 7,
    parameter int SEG_LOG2  = 5,
    localparam int CNT_W    = $clog2(LANES + 1),
    localparam int BYTES_W  = CNT_W + LINE_LOG2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_ready,
    input logic               txn_valid,
    input logic               txn_ready,
    input logic [ADDR_W-1:0]  txn_base,
    input logic [LANES-1:0]   txn_mask,
    input logic               done,
    input logic [CNT_W-1:0]   done_count,
    input logic [BYTES_W-1:0] done_bytes
);
    // R6
    txn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_mask)));

    // R7
    req_block_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready);

    // R4
    mask_used_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_mask != '0));

    // R3
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_base[SEG_LOG2-1:0] == '0));

    // R8
    done_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((done_bytes == (BYTES_W'(done_count) << LINE_LOG2)) ||
                  (done_bytes == (BYTES_W'(done_count) << SEG_LOG2))));

    // R8
    done_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!txn_valid && (done_count <= CNT_W'(LANES))));
endmodule

bind warp_coalescer coal_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2), .SEG_LOG2(SEG_LOG2)
) u_chk (.*);

// File: tb/warp_coalescer_tb.sv
`timescale 1ns/1ps
module warp_coalescer_tb;
    localparam int LANES = 32;
    localparam int AW    = 32;

    typedef struct packed {
        logic        rev;
        logic        seg;
        logic [31:0] base;
        logic [31:0] stride;
        logic [5:0]  exp_n;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 32'h1000, 32'd4,   6'd1},
        '{1'b0, 1'b1, 32'h1000, 32'd4,   6'd4},
        '{1'b1, 1'b0, 32'h1000, 32'd4,   6'd1},
        '{1'b1, 1'b1, 32'h1000, 32'd4,   6'd4},
        '{1'b0, 1'b0, 32'h1004, 32'd4,   6'd2},
        '{1'b0, 1'b1, 32'h1004, 32'd4,   6'd5},
        '{1'b0, 1'b0, 32'h1020, 32'd4,   6'd2},
        '{1'b0, 1'b1, 32'h1020, 32'd4,   6'd4},
        '{1'b0, 1'b0, 32'h2468, 32'd0,   6'd1},
        '{1'b0, 1'b1, 32'h2468, 32'd0,   6'd1},
        '{1'b0, 1'b0, 32'h0,    32'd128, 6'd32},
        '{1'b0, 1'b1, 32'h0,    32'd64,  6'd32},
        '{1'b0, 1'b0, 32'h0,    32'd64,  6'd16},
        '{1'b0, 1'b1, 32'h40,   32'd8,   6'd8}
    };

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 req_valid;
    logic                 req_ready;
    logic                 req_seg;
    logic [LANES-1:0]     req_active;
    logic [LANES*AW-1:0]  req_addr;
    logic                 txn_valid;
    logic                 txn_ready;
    logic [AW-1:0]        txn_base;
    logic [LANES-1:0]     txn_mask;
    logic                 done;
    logic [5:0]           done_count;
    logic [12:0]          done_bytes;

    always #2 clk = ~clk;

    warp_coalescer u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_active(req_active), .req_addr(req_addr),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_mask(txn_mask),
        .done(done), .done_count(done_count), .done_bytes(done_bytes)
    );

    int checks = 0;
    int errors = 0;

    logic [AW-1:0]    s_addr [LANES];
    logic [LANES-1:0] s_act;
    logic             s_seg;
    logic [AW-1:0]    e_base [LANES];
    logic [LANES-1:0] e_mask [LANES];
    int               e_n;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference: walk lanes upward, group unserved active lanes by aligned base
    task automatic model();
        logic [LANES-1:0] served = '0;
        logic [AW-1:0]    keep = s_seg ? ~32'h1F : ~32'h7F;
        e_n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (s_act[i] && !served[i]) begin
                logic [AW-1:0]    b = s_addr[i] & keep;
                logic [LANES-1:0] m = '0;
                for (int j = 0; j < LANES; j++)
                    if (s_act[j] && !served[j] && ((s_addr[j] & keep) == b)) m[j] = 1'b1;
                served   |= m;
                e_base[e_n] = b;
                e_mask[e_n] = m;
                e_n++;
            end
        end
    endtask

    task automatic run_warp(input bit stall, input string tg, output int got_n, output int cycles);
        int               hold = 0;
        bit               held = 0;
        logic [AW-1:0]    pb;
        logic [LANES-1:0] pm;
        model();
        @(negedge clk);
        check(req_ready == 1'b1, "R7", "req_ready before request", req_ready, 1);
        req_valid  = 1'b1;
        req_seg    = s_seg;
        req_active = s_act;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = s_addr[i];
        txn_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_n  = 0;
        cycles = 1;
        while (!done && cycles < 400) begin
            if (held) begin
                check(txn_valid && txn_base == pb && txn_mask == pm, "R6",
                      "output moved under stall", {txn_base, txn_mask}, {pb, pm});
                held = 0;
            end
            if (txn_valid) begin
                check(req_ready == 1'b0, "R7", "req_ready while busy", req_ready, 0);
                if (stall && hold < 2) begin
                    txn_ready = 1'b0;
                    pb = txn_base;
                    pm = txn_mask;
                    held = 1;
                    hold++;
                end else begin
                    txn_ready = 1'b1;
                    hold = 0;
                    if (got_n < e_n) begin
                        check(txn_base == e_base[got_n], tg, "txn_base", txn_base, e_base[got_n]);
                        check(txn_mask == e_mask[got_n], "R4", "txn_mask", txn_mask, e_mask[got_n]);
                    end
                    got_n++;
                end
            end
            @(negedge clk);
            cycles++;
        end
        txn_ready = 1'b1;
        check(done == 1'b1, "R8", "done pulse", done, 1);
        check(got_n == e_n, "R4", "transactions handed off", got_n, e_n);
        check(done_count == 6'(e_n), "R8", "done_count", done_count, e_n);
        check(done_bytes == 13'(e_n * (s_seg ? 32 : 128)), "R8", "done_bytes",
              done_bytes, e_n * (s_seg ? 32 : 128));
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, "R8", "done is one cycle", {done, req_ready}, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int cyc;
        rst = 1'b1; req_valid = 1'b0; req_seg = 1'b0; req_active = '0;
        req_addr = '0; txn_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(txn_valid == 1'b0, "R1", "txn_valid in reset", txn_valid, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst = 1'b0;

        // Table walk: R2/R3 counts and bases, R9 one per cycle
        for (int v = 0; v < NV; v++) begin
            s_seg = VECS[v].seg;
            s_act = '1;
            for (int i = 0; i < LANES; i++)
                s_addr[i] = VECS[v].base + VECS[v].stride * (VECS[v].rev ? (LANES - 1 - i) : i);
            run_warp(1'b0, s_seg ? "R3" : "R2", n, cyc);
            check(n == int'(VECS[v].exp_n), s_seg ? "R3" : "R2", "transaction count", n, VECS[v].exp_n);
            check(cyc == n + 1, "R9", "cycles to done", cyc, n + 1);
        end

        // R5: no active lanes
        s_seg = 1'b0;
        s_act = '0;
        for (int i = 0; i < LANES; i++) s_addr[i] = 32'h5000 + 32'(i) * 128;
        run_warp(1'b0, "R5", n, cyc);
        check(n == 0 && cyc == 1, "R5", "empty request", {n, cyc}, 1);

        // R5: inactive even lanes point at distinct lines and must be ignored
        s_act = 32'hAAAA_AAAA;
        for (int i = 0; i < LANES; i++) s_addr[i] = (i % 2 == 1) ? 32'h104 : 32'h9000 + 32'(i) * 128;
        run_warp(1'b0, "R2", n, cyc);
        check(n == 1 && e_mask[0] == 32'hAAAA_AAAA, "R5", "inactive lanes ignored", n, 1);

        // R6: back-pressure on a five-segment request
        s_seg = 1'b1;
        s_act = '1;
        for (int i = 0; i < LANES; i++) s_addr[i] = 32'h1004 + 32'(i) * 4;
        run_warp(1'b1, "R3", n, cyc);
        check(n == 5, "R6", "count under stall", n, 5);

        // R1: reset while busy drops the request
        @(negedge clk);
        req_valid = 1'b1; req_seg = 1'b0; req_active = '1;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = 32'(i) * 128;
        txn_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(txn_valid == 1'b1, "R1", "busy before reset", txn_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(txn_valid == 1'b0 && req_ready == 1'b1, "R1", "reset mid-request",
              {txn_valid, req_ready}, 1);
        txn_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && txn_valid == 1'b0, "R1", "no output after reset", {done, txn_valid}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule